// File: doc/BRIEF.md
# Configurable General-Purpose I/O Port

A port of `NUM_PINS` general-purpose pins (32 by default) on a simple single-cycle register bus. Software sets the output value and the direction of every pin. For each of these registers there is a plain register plus a set alias and a clear alias, so one write can change any group of pins and leave the rest as they are. Each pin also has its own configuration word. That word holds the pin's direction bit, a flag that disconnects the input buffer, and a two-bit pull selector. The direction bit in the configuration word and the matching bit of the port-wide direction register are one and the same storage.

For every pin the block resolves one level from three sources, in this order: an external driver if one is present, then the pin's own output if it is an output, then the selected pull. With no pull selected, a floating pin keeps its last level. The resolved level is registered and reported on the input register, masked by the input-buffer connection. A pin can be driven as an output while the external source forces the opposite level. The block flags this conflict with a one-cycle pulse on that pin's bit of a short-circuit vector, and the input register then shows the externally forced level.

Top module: `gpio_port`

## Requirements
- R1: After reset, the registers at word addresses 0x00 (output), 0x01 (output set), 0x02 (output clear), 0x03 (input), 0x04 (direction), 0x05 (direction set) and 0x06 (direction clear) all read 0. Every configuration word, at word address 0x40+n for pin n, reads 0x00000002.
- R2: A write to 0x05 sets the direction bits that are 1 in the write data, and a write to 0x06 clears them. A write to 0x04 replaces all bits. Reads of 0x05 and 0x06 return the direction register, and pad_oe_o equals the direction register.
- R3: Bit 0 of configuration word n is bit n of the direction register. A change made through either view reads back through the other, including at pins 0 and 31.
- R4: Configuration bit 1 set to 1 disconnects the input buffer, and the pin's input bit then reads 0 whatever the external level.
- R5: Configuration bits 3:2 select the pull: 2'b11 pull-up, 2'b01 pull-down, 2'b00 or 2'b10 no pull. A pull decides the level only when neither the external source nor the pin's output drives it.
- R6: A connected input pin reads the externally driven level. Once the external source releases the pin and no pull is selected, the pin keeps its last resolved level.
- R7: An output pin drives its output register bit on pad_out_o with pad_oe_o high. With its input connected, it reads that value back on the input register.
- R8: A write to 0x01 sets the output bits that are 1 in the write data, a write to 0x02 clears them, and a write to 0x00 replaces them. Reads of 0x01 and 0x02 return the output register.
- R9: When an output pin is externally driven to the opposite level, short_o for that pin is 1 for exactly one cycle, on the cycle after the conflict starts, and the input register reports the external level.
- R10: Read data appears on rdata_o on the cycle after a read request and holds until the next read. Unmapped addresses read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, registered |
| pad_drv_i | input | NUM_PINS | External source drives the pin |
| pad_lvl_i | input | NUM_PINS | Level of the external source |
| pad_out_o | output | NUM_PINS | Output value to the pads |
| pad_oe_o | output | NUM_PINS | Output enable to the pads |
| short_o | output | NUM_PINS | One-cycle pulse when a drive conflict starts |

## Verification
The bench builds the port with its default values: 32 pins, a 32-bit data bus and an 8-bit word address. With these values, pin 31 lands on the top bit of the data word and on the last configuration address, 0x5F. Both ends of the shared direction storage, pins 0 and 31, are therefore exercised through both register views. The pull, hold, readback and conflict cases are driven at the pads of pins 0 and 31 and read back on the input register and the pad outputs.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_OUT    = 8'h00;
  localparam logic [ADDR_W-1:0] A_OUTSET = 8'h01;
  localparam logic [ADDR_W-1:0] A_OUTCLR = 8'h02;
  localparam logic [ADDR_W-1:0] A_IN     = 8'h03;
  localparam logic [ADDR_W-1:0] A_DIR    = 8'h04;
  localparam logic [ADDR_W-1:0] A_DIRSET = 8'h05;
  localparam logic [ADDR_W-1:0] A_DIRCLR = 8'h06;
  localparam int unsigned       CFG_BASE = 'h40;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_DOWN = 2'b01,
    PULL_RSVD = 2'b10,
    PULL_UP   = 2'b11
  } pull_e;

  typedef struct packed {
    logic [1:0] pull;
    logic       disc;
    logic       dir;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RST = '{pull: PULL_NONE, disc: 1'b1, dir: 1'b0};
endpackage

// File: rtl/gpio_pin.sv
module gpio_pin
  import gpio_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       out_i,
  input  logic       oe_i,
  input  logic [1:0] pull_i,
  input  logic       ext_drv_i,
  input  logic       ext_lvl_i,
  output logic       level_o,
  output logic       short_o
);
  logic level_q, level_d;
  logic conflict, conflict_q, short_q;

  // priority: external source, own driver, pull, keeper
  always_comb begin
    if (ext_drv_i)              level_d = ext_lvl_i;
    else if (oe_i)              level_d = out_i;
    else if (pull_i == PULL_UP) level_d = 1'b1;
    else if (pull_i == PULL_DOWN) level_d = 1'b0;
    else                        level_d = level_q;
  end

  assign conflict = ext_drv_i & oe_i & (ext_lvl_i ^ out_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q    <= 1'b0;
      conflict_q <= 1'b0;
      short_q    <= 1'b0;
    end else begin
      level_q    <= level_d;
      conflict_q <= conflict;
      short_q    <= conflict & ~conflict_q;
    end
  end

  assign level_o = level_q;
  assign short_o = short_q;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic [NUM_PINS-1:0]   level_i,
  output logic [NUM_PINS-1:0]   out_o,
  output logic [NUM_PINS-1:0]   dir_o,
  output logic [NUM_PINS-1:0]   disc_o,
  output logic [2*NUM_PINS-1:0] pull_o,
  output logic [DW-1:0]         rdata_o
);
  localparam int unsigned CFG_W = $bits(pin_cfg_t);

  logic [NUM_PINS-1:0]   out_q, out_d, dir_q, dir_d, disc_q, disc_d;
  logic [2*NUM_PINS-1:0] pull_q, pull_d;
  logic [DW-1:0]         rdata_q, rdata_d;
  logic [NUM_PINS-1:0]   wmask;
  logic                  wr, rd;

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign wmask = wdata_i[NUM_PINS-1:0];

  always_comb begin
    out_d  = out_q;
    dir_d  = dir_q;
    disc_d = disc_q;
    pull_d = pull_q;
    if (wr) begin
      case (addr_i)
        AW'(A_OUT):    out_d = wmask;
        AW'(A_OUTSET): out_d = out_q | wmask;
        AW'(A_OUTCLR): out_d = out_q & ~wmask;
        AW'(A_DIR):    dir_d = wmask;
        AW'(A_DIRSET): dir_d = dir_q | wmask;
        AW'(A_DIRCLR): dir_d = dir_q & ~wmask;
        default: begin
          for (int n = 0; n < NUM_PINS; n++) begin
            if (addr_i == AW'(CFG_BASE + n)) begin
              dir_d[n]          = wdata_i[0];
              disc_d[n]         = wdata_i[1];
              pull_d[2*n +: 2]  = wdata_i[3:2];
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    rdata_d = '0;
    case (addr_i)
      AW'(A_OUT), AW'(A_OUTSET), AW'(A_OUTCLR): rdata_d[NUM_PINS-1:0] = out_q;
      AW'(A_DIR), AW'(A_DIRSET), AW'(A_DIRCLR): rdata_d[NUM_PINS-1:0] = dir_q;
      AW'(A_IN): rdata_d[NUM_PINS-1:0] = level_i & ~disc_q;
      default: begin
        for (int n = 0; n < NUM_PINS; n++) begin
          if (addr_i == AW'(CFG_BASE + n))
            rdata_d[CFG_W-1:0] = {pull_q[2*n +: 2], disc_q[n], dir_q[n]};
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= {NUM_PINS{CFG_RST.dir}};
      disc_q  <= {NUM_PINS{CFG_RST.disc}};
      pull_q  <= {NUM_PINS{CFG_RST.pull}};
      rdata_q <= '0;
    end else begin
      out_q  <= out_d;
      dir_q  <= dir_d;
      disc_q <= disc_d;
      pull_q <= pull_d;
      if (rd) rdata_q <= rdata_d;
    end
  end

  assign out_o   = out_q;
  assign dir_o   = dir_q;
  assign disc_o  = disc_q;
  assign pull_o  = pull_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = ADDR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  input  logic [NUM_PINS-1:0] pad_drv_i,
  input  logic [NUM_PINS-1:0] pad_lvl_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] short_o
);
  logic [NUM_PINS-1:0]   out_w, dir_w, disc_w, level_w;
  logic [2*NUM_PINS-1:0] pull_w;

  gpio_port_regs #(.NUM_PINS(NUM_PINS), .DW(DW), .AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .level_i (level_w),
    .out_o   (out_w),
    .dir_o   (dir_w),
    .disc_o  (disc_w),
    .pull_o  (pull_w),
    .rdata_o (rdata_o)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    gpio_pin u_pin (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .out_i     (out_w[n]),
      .oe_i      (dir_w[n]),
      .pull_i    (pull_w[2*n +: 2]),
      .ext_drv_i (pad_drv_i[n]),
      .ext_lvl_i (pad_lvl_i[n]),
      .level_o   (level_w[n]),
      .short_o   (short_o[n])
    );
  end

  assign pad_out_o = out_w;
  assign pad_oe_o  = dir_w;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [AW-1:0]       addr_i,
  input logic [DW-1:0]       wdata_i,
  input logic [NUM_PINS-1:0] pad_drv_i,
  input logic [NUM_PINS-1:0] pad_lvl_i,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] short_o
);
  logic [NUM_PINS-1:0] m;
  assign m = wdata_i[NUM_PINS-1:0];

  AST_DIRSET_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(A_DIRSET)) |=> ((pad_oe_o & $past(m)) == $past(m))); // R2

  AST_DIRCLR_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(A_DIRCLR)) |=> ((pad_oe_o & $past(m)) == '0)); // R2

  AST_OUTSET_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(A_OUTSET)) |=> ((pad_out_o & $past(m)) == $past(m))); // R8

  AST_OUTCLR_KEEPS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(A_OUTCLR)) |=> $stable(pad_oe_o)); // R7

  AST_SHORT_NEEDS_CONFLICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_o & ~$past(pad_drv_i & pad_oe_o & (pad_lvl_i ^ pad_out_o))) == '0); // R9

  AST_SHORT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_o & $past(short_o)) == '0); // R9
endmodule

bind gpio_port gpio_port_chk #(.NUM_PINS(NUM_PINS), .DW(DW), .AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .pad_drv_i (pad_drv_i),
  .pad_lvl_i (pad_lvl_i),
  .pad_out_o (pad_out_o),
  .pad_oe_o  (pad_oe_o),
  .short_o   (short_o)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
  localparam int NP = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] drv = '0, lvl = '0;
  logic [NP-1:0] pout, poe, shrt;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  gpio_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_drv_i(drv), .pad_lvl_i(lvl),
    .pad_out_o(pout), .pad_oe_o(poe), .short_o(shrt)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [3:0]  req_no;
  } op_t;

  localparam int NOPS = 28;
  localparam op_t TBL [NOPS] = '{
    '{1'b0, 8'h00, 32'h0,        4'd1},  // R1
    '{1'b0, 8'h01, 32'h0,        4'd1},  // R1
    '{1'b0, 8'h02, 32'h0,        4'd1},  // R1
    '{1'b0, 8'h03, 32'h0,        4'd1},  // R1
    '{1'b0, 8'h04, 32'h0,        4'd1},  // R1
    '{1'b0, 8'h05, 32'h0,        4'd1},  // R1
    '{1'b0, 8'h06, 32'h0,        4'd1},  // R1
    '{1'b0, 8'h40, 32'h2,        4'd1},  // R1
    '{1'b0, 8'h5F, 32'h2,        4'd1},  // R1
    '{1'b1, 8'h05, 32'h80000001, 4'd2},  // R2
    '{1'b0, 8'h04, 32'h80000001, 4'd2},  // R2
    '{1'b0, 8'h40, 32'h3,        4'd3},  // R3
    '{1'b0, 8'h5F, 32'h3,        4'd3},  // R3
    '{1'b1, 8'h06, 32'h80000001, 4'd2},  // R2
    '{1'b0, 8'h04, 32'h0,        4'd2},  // R2
    '{1'b0, 8'h40, 32'h2,        4'd3},  // R3
    '{1'b1, 8'h04, 32'h80000001, 4'd2},  // R2
    '{1'b0, 8'h06, 32'h80000001, 4'd2},  // R2
    '{1'b1, 8'h5F, 32'h2,        4'd3},  // R3
    '{1'b0, 8'h04, 32'h00000001, 4'd3},  // R3
    '{1'b1, 8'h04, 32'h0,        4'd2},  // R2
    '{1'b1, 8'h01, 32'h5,        4'd8},  // R8
    '{1'b0, 8'h00, 32'h5,        4'd8},  // R8
    '{1'b1, 8'h02, 32'h1,        4'd8},  // R8
    '{1'b0, 8'h02, 32'h4,        4'd8},  // R8
    '{1'b1, 8'h3F, 32'hFFFFFFFF, 4'd10}, // R10
    '{1'b0, 8'h3F, 32'h0,        4'd10}, // R10
    '{1'b0, 8'h01, 32'h4,        4'd10}  // R10
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic in_bit(input int p, input logic exp, input string tag);
    logic [31:0] v;
    rd(8'h03, v);
    check(tag, {31'b0, v[p]}, {31'b0, exp});
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: all configuration words at reset
    for (int p = 0; p < NP; p++) begin
      rd(8'(8'h40 + p), v);
      check("R1 cfg reset", v, 32'h2);
    end

    for (int i = 0; i < NOPS; i++) begin
      if (TBL[i].wr) wr(TBL[i].a, TBL[i].d);
      else begin
        rd(TBL[i].a, v);
        check($sformatf("R%0d table step %0d", TBL[i].req_no, i), v, TBL[i].d);
      end
    end

    // R6: connected input follows external drive, then holds
    wr(8'h40, 32'h0);
    @(negedge clk); drv[0] = 1'b1; lvl[0] = 1'b0;
    in_bit(0, 1'b0, "R6 ext low");
    @(negedge clk); lvl[0] = 1'b1;
    in_bit(0, 1'b1, "R6 ext high");
    @(negedge clk); drv[0] = 1'b0;
    in_bit(0, 1'b1, "R6 hold after release");

    // R4: disconnected input reads 0
    @(negedge clk); drv[0] = 1'b1; lvl[0] = 1'b1;
    wr(8'h40, 32'h2);
    in_bit(0, 1'b0, "R4 disconnected");
    @(negedge clk); drv[0] = 1'b0; lvl[0] = 1'b0;

    // R5: pulls on a floating input
    wr(8'h40, 32'h4);
    in_bit(0, 1'b0, "R5 pull down");
    wr(8'h40, 32'hC);
    in_bit(0, 1'b1, "R5 pull up");
    wr(8'h40, 32'h0);
    in_bit(0, 1'b1, "R6 keeper after pull-up");
    wr(8'h40, 32'h4);
    wr(8'h40, 32'h8);
    in_bit(0, 1'b0, "R5 reserved pull keeps");
    @(negedge clk); drv[0] = 1'b1; lvl[0] = 1'b1;
    wr(8'h40, 32'h4);
    in_bit(0, 1'b1, "R5 drive beats pull");
    @(negedge clk); drv[0] = 1'b0; lvl[0] = 1'b0;
    wr(8'h5F, 32'hC);
    in_bit(31, 1'b1, "R5 pull up pin 31");

    // R7: output pads, disconnected input
    wr(8'h40, 32'h3);
    wr(8'h01, 32'h1);
    check("R7 pad_out set", {31'b0, pout[0]}, 32'h1);
    check("R7 pad_oe", {31'b0, poe[0]}, 32'h1);
    in_bit(0, 1'b0, "R4 output disconnected");
    wr(8'h02, 32'h1);
    check("R7 pad_out clear", {31'b0, pout[0]}, 32'h0);

    // R7: readback with input connected
    wr(8'h40, 32'h1);
    wr(8'h01, 32'h1);
    in_bit(0, 1'b1, "R7 readback high");
    wr(8'h02, 32'h1);
    in_bit(0, 1'b0, "R7 readback low");

    // R9: conflict pulse
    wr(8'h01, 32'h1);
    check("R9 no short before", {31'b0, shrt[0]}, 32'h0);
    @(negedge clk); drv[0] = 1'b1; lvl[0] = 1'b0;
    @(negedge clk);
    check("R9 short pulse", {31'b0, shrt[0]}, 32'h1);
    @(negedge clk);
    check("R9 short ends", {31'b0, shrt[0]}, 32'h0);
    in_bit(0, 1'b0, "R9 ext level wins");
    check("R9 no second pulse", {31'b0, shrt[0]}, 32'h0);
    @(negedge clk); drv[0] = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule